// File: doc/BRIEF.md
# NAND Flash Asynchronous Cycle Sequencer

This block turns single requests into asynchronous NAND flash bus cycles and times them on one functional clock. A request picks one of four cycle kinds: command write, address write, data write or data read. A write cycle drives chip select, one latch enable (or none for data), the 16-bit data bus and a write-enable pulse. These signals nest around the pulse in a fixed order. A read cycle drives chip select and an output-enable pulse. It samples the flash data bus at a programmed access point and returns that word together with a one-cycle done strobe.

Every phase of a cycle lasts a programmable number of clock cycles. Each 4-bit timing field is multiplied by a granularity factor. The timing fields describe consecutive gaps between edges, so no setting can reorder the edges. A field of zero still yields one clock cycle. All bus outputs come from flops, so their delays from the clock edge match.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is held and after it is released with no request, chip select, write enable and output enable are high, both latch enables are low, the data bus is not driven, done is low and req_ready is high.
- R2: Every programmed span lasts max(1, field × (cfg_gran + 1)) clock cycles. Call this L(field). Bus cycle 1 is the first cycle with chip select low. It is the cycle after the edge that accepts the request.
- R3: In a write, chip select is low from cycle 1. The latch enable rises after L(cs_le). The data bus is driven after a further L(le_dat). Write enable falls after a further L(dat_we) and stays low for L(we_pw) cycles.
- R4: After write enable rises, the data bus is released after L(dat_hold). The latch enable then falls after a further L(le_hold). Chip select then rises after a further L(cs_hold).
- R5: Request opcode 0 (command) raises only CLE. Opcode 1 (address) raises only ALE. Opcode 2 (data write) raises neither. Opcode 3 is a read.
- R6: The data bus enable is high only in the write-data span of R3/R4, with the request's write word on the bus. It is never high in a read.
- R7: In a read, output enable falls after L(cs_oe) cycles of chip select. It stays low for L(oe_pw). Chip select rises L(cs_hold) after output enable rises. Write enable stays high.
- R8: rd_data holds the value of nand_dq_in sampled at the clock edge that ends bus cycle J, where J = L(acc).
- R9: A bus cycle lasts T = max(span sum, L(wr_cyc) or L(rd_cyc), and J for reads) cycles. done is high for exactly one clock, in cycle T + 1, and the bus is idle then.
- R10: A request is accepted only while req_ready is high. req_ready is low for the whole bus cycle, and req_valid during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Cycle kind: 0 command, 1 address, 2 data write, 3 read |
| req_wdata | input | 16 | Word for command, address or data write |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle end-of-cycle strobe |
| rd_data | output | 16 | Word captured by the last read |
| cfg_gran | input | 1 | Granularity: field multiplier is cfg_gran + 1 |
| cfg_cs_le | input | 4 | Chip select to latch enable gap |
| cfg_le_dat | input | 4 | Latch enable to data valid gap |
| cfg_dat_we | input | 4 | Data valid to write enable gap |
| cfg_we_pw | input | 4 | Write enable pulse width |
| cfg_dat_hold | input | 4 | Write enable rise to data release |
| cfg_le_hold | input | 4 | Data release to latch enable fall |
| cfg_cs_hold | input | 4 | Last strobe release to chip select rise |
| cfg_wr_cyc | input | 4 | Minimum write cycle time |
| cfg_cs_oe | input | 4 | Chip select to output enable gap |
| cfg_oe_pw | input | 4 | Output enable pulse width |
| cfg_rd_cyc | input | 4 | Minimum read cycle time |
| cfg_acc | input | 4 | Read access time, capture point |
| nand_cs_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_ale | output | 1 | Address latch enable, active high |
| nand_we_n | output | 1 | Write enable, active low |
| nand_oe_n | output | 1 | Output enable, active low |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 16 | Data bus input value |

## Verification
The flash model puts a cycle-indexed word on the data bus each cycle, so the captured word shows exactly which edge sampled it. A capture point off by one, or a granularity applied to the wrong field, gives a wrong low byte. The bench records the first and last cycle of every strobe, with all fields at zero, with doubled granularity, and with a cycle time longer than the span sum. A design that lost the nesting, ignored the minimum of one cycle or ended the cycle early would show a wrong edge position or a wrong done cycle. A request poked mid-cycle must leave the bus untouched after done. A design that queued it would start a second cycle.

// File: rtl/nand_seq_pkg.sv
// Package: shared encodings for the NAND cycle sequencer.
// Holds the request opcodes, the sequencer states and the index of every
// timing field in the packed length array passed between modules.
package nand_seq_pkg;

    localparam int NF         = 12;
    localparam int F_CS_LE    = 0;
    localparam int F_LE_DAT   = 1;
    localparam int F_DAT_WE   = 2;
    localparam int F_WE_PW    = 3;
    localparam int F_DAT_HOLD = 4;
    localparam int F_LE_HOLD  = 5;
    localparam int F_CS_HOLD  = 6;
    localparam int F_WR_CYC   = 7;
    localparam int F_CS_OE    = 8;
    localparam int F_OE_PW    = 9;
    localparam int F_RD_CYC   = 10;
    localparam int F_ACC      = 11;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_READ  = 2'd3
    } nand_op_e;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_W_CS = 4'd1,
        ST_W_LE = 4'd2,
        ST_W_DAT = 4'd3,
        ST_W_WE = 4'd4,
        ST_W_HD = 4'd5,
        ST_W_HL = 4'd6,
        ST_W_HC = 4'd7,
        ST_R_CS = 4'd8,
        ST_R_OE = 4'd9,
        ST_R_HC = 4'd10,
        ST_REC  = 4'd11
    } seq_state_e;

endpackage

// File: rtl/nand_len_scale.sv
// Module: nand_len_scale
// Turns one raw timing field into a span length in clock cycles:
// max(1, field * (gran + 1)). Purely combinational.
// Assumes LW >= TW + GW so the product cannot overflow.
module nand_len_scale #(
    parameter int TW = 4,
    parameter int GW = 1,
    parameter int LW = TW + GW
) (
    input  logic [TW-1:0] field,
    input  logic [GW-1:0] gran,
    output logic [LW-1:0] len
);

    logic [LW-1:0] mult;

    // Scale the field; a zero field still gives one cycle.
    always_comb begin
        mult = LW'(gran) + LW'(1);
        if (field == '0) begin
            len = LW'(1);
        end else begin
            len = LW'(field) * mult;
        end
    end

endmodule

// File: rtl/nand_seq_fsm.sv
// Module: nand_seq_fsm
// Walks the phases of one bus cycle, counts cycles inside each phase and
// across the whole bus cycle, and registers every bus control output from
// the next-state decode so all strobes leave flops together.
// Assumes lens[] holds scaled lengths of at least 1 and is held stable
// while a bus cycle runs.
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int LW = 5,
    parameter int CW = LW + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [NF-1:0][LW-1:0]  lens,
    output seq_state_e             state_q,
    output logic [CW-1:0]          cyc_q,
    output logic                   rd_q,
    output logic                   req_ready,
    output logic                   done,
    output logic                   cs_n,
    output logic                   cle,
    output logic                   ale,
    output logic                   we_n,
    output logic                   oe_n,
    output logic                   dq_oe
);

    seq_state_e    ns;
    nand_op_e      op_q, op_d;
    logic [LW-1:0] pc_q, pc_d;
    logic [CW-1:0] cyc_d;
    logic [LW-1:0] phase_len;
    logic [LW-1:0] cyc_len;
    logic          last;
    logic          cyc_ok;
    logic          cs_d, le_d, we_d, oe_d, dqoe_d;

    assign rd_q      = (op_q == OP_READ);
    assign req_ready = (state_q == ST_IDLE);

    // Length of the phase currently being timed.
    always_comb begin
        case (state_q)
            ST_W_CS:  phase_len = lens[F_CS_LE];
            ST_W_LE:  phase_len = lens[F_LE_DAT];
            ST_W_DAT: phase_len = lens[F_DAT_WE];
            ST_W_WE:  phase_len = lens[F_WE_PW];
            ST_W_HD:  phase_len = lens[F_DAT_HOLD];
            ST_W_HL:  phase_len = lens[F_LE_HOLD];
            ST_W_HC:  phase_len = lens[F_CS_HOLD];
            ST_R_CS:  phase_len = lens[F_CS_OE];
            ST_R_OE:  phase_len = lens[F_OE_PW];
            ST_R_HC:  phase_len = lens[F_CS_HOLD];
            default:  phase_len = LW'(1);
        endcase
    end

    // End-of-phase and end-of-cycle conditions.
    always_comb begin
        last    = (pc_q == phase_len - LW'(1));
        cyc_len = rd_q ? lens[F_RD_CYC] : lens[F_WR_CYC];
        cyc_ok  = (cyc_q >= CW'(cyc_len)) &&
                  (!rd_q || (cyc_q >= CW'(lens[F_ACC])));
    end

    // Next state, phase counter, cycle counter and latched opcode.
    always_comb begin
        ns    = state_q;
        pc_d  = pc_q;
        cyc_d = cyc_q;
        op_d  = op_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    op_d  = nand_op_e'(req_op);
                    ns    = (nand_op_e'(req_op) == OP_READ) ? ST_R_CS : ST_W_CS;
                    pc_d  = '0;
                    cyc_d = CW'(1);
                end
            end
            ST_REC: begin
                cyc_d = cyc_q + CW'(1);
                if (cyc_ok) begin
                    ns = ST_IDLE;
                end
            end
            default: begin
                cyc_d = cyc_q + CW'(1);
                if (last) begin
                    pc_d = '0;
                    case (state_q)
                        ST_W_CS:  ns = ST_W_LE;
                        ST_W_LE:  ns = ST_W_DAT;
                        ST_W_DAT: ns = ST_W_WE;
                        ST_W_WE:  ns = ST_W_HD;
                        ST_W_HD:  ns = ST_W_HL;
                        ST_W_HL:  ns = ST_W_HC;
                        ST_R_CS:  ns = ST_R_OE;
                        ST_R_OE:  ns = ST_R_HC;
                        default:  ns = cyc_ok ? ST_IDLE : ST_REC;
                    endcase
                end else begin
                    pc_d = pc_q + LW'(1);
                end
            end
        endcase
    end

    // Decode of the strobes that the next state asks for.
    always_comb begin
        cs_d   = (ns inside {[ST_W_CS:ST_W_HC], [ST_R_CS:ST_R_HC]});
        le_d   = (ns inside {[ST_W_LE:ST_W_HL]});
        we_d   = (ns == ST_W_WE);
        oe_d   = (ns == ST_R_OE);
        dqoe_d = (ns inside {[ST_W_DAT:ST_W_HD]});
    end

    // Sequencer state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            cyc_q   <= '0;
            op_q    <= OP_CMD;
        end else begin
            state_q <= ns;
            pc_q    <= pc_d;
            cyc_q   <= cyc_d;
            op_q    <= op_d;
        end
    end

    // Registered bus strobes and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            cle   <= 1'b0;
            ale   <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b0;
        end else begin
            cs_n  <= !cs_d;
            cle   <= le_d && (op_d == OP_CMD);
            ale   <= le_d && (op_d == OP_ADDR);
            we_n  <= !we_d;
            oe_n  <= !oe_d;
            dq_oe <= dqoe_d;
            done  <= (state_q != ST_IDLE) && (ns == ST_IDLE);
        end
    end

endmodule

// File: rtl/nand_data_path.sv
// Module: nand_data_path
// Latches the write word when a request is accepted and captures the
// flash data bus at the edge that closes bus cycle J of a read.
// Assumes cyc_q counts 1 in the first chip-select cycle.
module nand_data_path #(
    parameter int DW = 16,
    parameter int LW = 5,
    parameter int CW = LW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [DW-1:0] wdata,
    input  logic          active,
    input  logic          rd,
    input  logic [CW-1:0] cyc_q,
    input  logic [LW-1:0] acc_len,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rd_data
);

    logic cap_en;

    assign cap_en = active && rd && (cyc_q == CW'(acc_len));

    // Hold the outgoing word for the whole write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
        end else if (accept) begin
            dq_out <= wdata;
        end
    end

    // Sample the bus once the access time has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (cap_en) begin
            rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/nand_cycle_seq.sv
// Module: nand_cycle_seq (top)
// Asynchronous NAND bus cycle sequencer. Scales every raw timing field by
// the granularity, runs the phase FSM and the data path.
// Assumes the cfg_* inputs are static while a bus cycle is in progress.
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 4,
    parameter int GW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    input  logic [GW-1:0] cfg_gran,
    input  logic [TW-1:0] cfg_cs_le,
    input  logic [TW-1:0] cfg_le_dat,
    input  logic [TW-1:0] cfg_dat_we,
    input  logic [TW-1:0] cfg_we_pw,
    input  logic [TW-1:0] cfg_dat_hold,
    input  logic [TW-1:0] cfg_le_hold,
    input  logic [TW-1:0] cfg_cs_hold,
    input  logic [TW-1:0] cfg_wr_cyc,
    input  logic [TW-1:0] cfg_cs_oe,
    input  logic [TW-1:0] cfg_oe_pw,
    input  logic [TW-1:0] cfg_rd_cyc,
    input  logic [TW-1:0] cfg_acc,
    output logic          nand_cs_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_oe_n,
    output logic [DW-1:0] nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_in
);

    localparam int LW = TW + GW;
    localparam int CW = LW + 3;

    logic [NF-1:0][TW-1:0] fields;
    logic [NF-1:0][LW-1:0] lens;
    seq_state_e            state_q;
    logic [CW-1:0]         cyc_q;
    logic                  rd_q;

    assign fields[F_CS_LE]    = cfg_cs_le;
    assign fields[F_LE_DAT]   = cfg_le_dat;
    assign fields[F_DAT_WE]   = cfg_dat_we;
    assign fields[F_WE_PW]    = cfg_we_pw;
    assign fields[F_DAT_HOLD] = cfg_dat_hold;
    assign fields[F_LE_HOLD]  = cfg_le_hold;
    assign fields[F_CS_HOLD]  = cfg_cs_hold;
    assign fields[F_WR_CYC]   = cfg_wr_cyc;
    assign fields[F_CS_OE]    = cfg_cs_oe;
    assign fields[F_OE_PW]    = cfg_oe_pw;
    assign fields[F_RD_CYC]   = cfg_rd_cyc;
    assign fields[F_ACC]      = cfg_acc;

    // One scaler per timing field.
    for (genvar gi = 0; gi < NF; gi++) begin : g_scale
        nand_len_scale #(.TW(TW), .GW(GW), .LW(LW)) i_scale (
            .field (fields[gi]),
            .gran  (cfg_gran),
            .len   (lens[gi])
        );
    end

    nand_seq_fsm #(.LW(LW), .CW(CW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .lens      (lens),
        .state_q   (state_q),
        .cyc_q     (cyc_q),
        .rd_q      (rd_q),
        .req_ready (req_ready),
        .done      (done),
        .cs_n      (nand_cs_n),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .oe_n      (nand_oe_n),
        .dq_oe     (nand_dq_oe)
    );

    nand_data_path #(.DW(DW), .LW(LW), .CW(CW)) i_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (req_ready && req_valid),
        .wdata   (req_wdata),
        .active  (state_q != ST_IDLE),
        .rd      (rd_q),
        .cyc_q   (cyc_q),
        .acc_len (lens[F_ACC]),
        .dq_in   (nand_dq_in),
        .dq_out  (nand_dq_out),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/nand_seq_checker.sv
// Module: nand_seq_checker
// Protocol properties on the bus pins of nand_cycle_seq, bound to the top.
module nand_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic done,
    input logic req_ready
);

    p_le_after_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cle || ale) |-> ($past(cs_n) == 1'b0));

    p_we_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($past(dq_oe) == 1'b1));

    p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);

    p_data_release_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> (!cs_n && we_n));

    p_cs_release_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!dq_oe && !cle && !ale));

    p_latch_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    p_no_drive_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);

    p_oe_inside_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!cs_n && we_n));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);

endmodule

bind nand_cycle_seq nand_seq_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (nand_cs_n),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .oe_n      (nand_oe_n),
    .dq_oe     (nand_dq_oe),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/test_nand_cycle_seq.sv
// Directed bench for nand_cycle_seq: one task per scenario.
module test_nand_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic [0:0]  cfg_gran = 1'b0;
    logic [3:0]  cfg_cs_le = 0, cfg_le_dat = 0, cfg_dat_we = 0, cfg_we_pw = 0;
    logic [3:0]  cfg_dat_hold = 0, cfg_le_hold = 0, cfg_cs_hold = 0, cfg_wr_cyc = 0;
    logic [3:0]  cfg_cs_oe = 0, cfg_oe_pw = 0, cfg_rd_cyc = 0, cfg_acc = 0;
    logic        nand_cs_n, nand_cle, nand_ale, nand_we_n, nand_oe_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = 16'h0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nand_cycle_seq i_nand_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .cfg_gran(cfg_gran), .cfg_cs_le(cfg_cs_le), .cfg_le_dat(cfg_le_dat),
        .cfg_dat_we(cfg_dat_we), .cfg_we_pw(cfg_we_pw), .cfg_dat_hold(cfg_dat_hold),
        .cfg_le_hold(cfg_le_hold), .cfg_cs_hold(cfg_cs_hold), .cfg_wr_cyc(cfg_wr_cyc),
        .cfg_cs_oe(cfg_cs_oe), .cfg_oe_pw(cfg_oe_pw), .cfg_rd_cyc(cfg_rd_cyc),
        .cfg_acc(cfg_acc), .nand_cs_n(nand_cs_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int lenf(input logic [3:0] f);
        return (f == 0) ? 1 : int'(f) * (int'(cfg_gran) + 1);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic set_wr(input int g, input int a, input int b, input int c, input int d,
                          input int e, input int f, input int h, input int cyc);
        cfg_gran = g[0:0];
        cfg_cs_le = a[3:0]; cfg_le_dat = b[3:0]; cfg_dat_we = c[3:0]; cfg_we_pw = d[3:0];
        cfg_dat_hold = e[3:0]; cfg_le_hold = f[3:0]; cfg_cs_hold = h[3:0]; cfg_wr_cyc = cyc[3:0];
    endtask

    task automatic set_rd(input int g, input int p, input int q, input int h,
                          input int cyc, input int acc);
        cfg_gran = g[0:0];
        cfg_cs_oe = p[3:0]; cfg_oe_pw = q[3:0]; cfg_cs_hold = h[3:0];
        cfg_rd_cyc = cyc[3:0]; cfg_acc = acc[3:0];
    endtask

    // Issues one request, samples every bus cycle at the falling edge and
    // compares edge positions with values computed from the requirements.
    task automatic run_xfer(input string nm, input int op, input logic [15:0] wd, input int poke);
        int cs_f = 0, cs_l = 0, le_f = 0, le_l = 0, dq_f = 0, dq_l = 0;
        int we_f = 0, we_l = 0, oe_f = 0, oe_l = 0, k_done = 0;
        int n_cle = 0, n_ale = 0, dq_bad = 0, rdy_busy = 0, post_bad = 0;
        int a, b, c, d, e, f, h, s, t, j;
        @(negedge clk);
        req_valid = 1'b1; req_op = op[1:0]; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
        for (int k = 1; k < 400; k++) begin
            if (k == poke) begin req_valid = 1'b1; req_op = 2'd3; end
            if (k == poke + 2) req_valid = 1'b0;
            if (done) begin k_done = k; break; end
            if (!nand_cs_n) begin if (cs_f == 0) cs_f = k; cs_l = k; end
            if (!nand_cs_n && req_ready) rdy_busy++;
            if (nand_cle || nand_ale) begin if (le_f == 0) le_f = k; le_l = k; end
            if (nand_cle) n_cle++;
            if (nand_ale) n_ale++;
            if (nand_dq_oe) begin
                if (dq_f == 0) dq_f = k; dq_l = k;
                if (nand_dq_out != wd) dq_bad++;
            end
            if (!nand_we_n) begin if (we_f == 0) we_f = k; we_l = k; end
            if (!nand_oe_n) begin if (oe_f == 0) oe_f = k; oe_l = k; end
            nand_dq_in = 16'h1000 + 16'(k);
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done || !nand_cs_n || !nand_oe_n || !nand_we_n) post_bad++;
        end
        if (op == 3) begin
            a = lenf(cfg_cs_oe); b = lenf(cfg_oe_pw); h = lenf(cfg_cs_hold);
            s = a + b + h; j = lenf(cfg_acc);
            t = imax(imax(s, lenf(cfg_rd_cyc)), j);
            chk({nm, " R7 cs first"}, cs_f, 1);
            chk({nm, " R7 oe first"}, oe_f, a + 1);
            chk({nm, " R7 oe last"}, oe_l, a + b);
            chk({nm, " R7 cs last"}, cs_l, s);
            chk({nm, " R7 we never low"}, we_f, 0);
            chk({nm, " R6 no drive in read"}, dq_f, 0);
            chk({nm, " R8 captured word"}, int'(rd_data), 16'h1000 + j);
        end else begin
            a = lenf(cfg_cs_le); b = lenf(cfg_le_dat); c = lenf(cfg_dat_we);
            d = lenf(cfg_we_pw); e = lenf(cfg_dat_hold); f = lenf(cfg_le_hold);
            h = lenf(cfg_cs_hold); s = a + b + c + d + e + f + h;
            t = imax(s, lenf(cfg_wr_cyc));
            chk({nm, " R3 cs first"}, cs_f, 1);
            chk({nm, " R3 data first"}, dq_f, a + b + 1);
            chk({nm, " R3 we first"}, we_f, a + b + c + 1);
            chk({nm, " R3 we last"}, we_l, a + b + c + d);
            chk({nm, " R4 data last"}, dq_l, a + b + c + d + e);
            chk({nm, " R4 cs last"}, cs_l, s);
            chk({nm, " R6 data word"}, dq_bad, 0);
            chk({nm, " R7 oe never low"}, oe_f, 0);
            if (op == 2) begin
                chk({nm, " R5 no latch"}, le_f, 0);
            end else begin
                chk({nm, " R3 latch first"}, le_f, a + 1);
                chk({nm, " R4 latch last"}, le_l, a + b + c + d + e + f);
                chk({nm, " R5 cle cycles"}, n_cle, (op == 0) ? (b + c + d + e + f) : 0);
                chk({nm, " R5 ale cycles"}, n_ale, (op == 1) ? (b + c + d + e + f) : 0);
            end
        end
        chk({nm, " R9 done cycle"}, k_done, t + 1);
        chk({nm, " R9 R10 bus idle after done"}, post_bad, 0);
        chk({nm, " R10 ready low while busy"}, rdy_busy, 0);
    endtask

    task automatic test_reset();
        chk("R1 cs_n", int'(nand_cs_n), 1);
        chk("R1 we_n", int'(nand_we_n), 1);
        chk("R1 oe_n", int'(nand_oe_n), 1);
        chk("R1 latches", int'(nand_cle) + int'(nand_ale), 0);
        chk("R1 dq_oe", int'(nand_dq_oe), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 ready", int'(req_ready), 1);
    endtask

    task automatic test_cmd_write();
        set_wr(0, 2, 1, 1, 3, 1, 2, 1, 4);
        run_xfer("cmd", 0, 16'h00A5, 0);
    endtask

    task automatic test_addr_gran();   // R2 granularity doubles each span
        set_wr(1, 2, 1, 1, 3, 1, 2, 1, 4);
        run_xfer("R2 addr gran", 1, 16'h0123, 0);
    endtask

    task automatic test_zero_fields(); // R2 zero gives one cycle
        set_wr(0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_xfer("R2 zero data", 2, 16'hBEEF, 0);
    endtask

    task automatic test_cycle_stretch();
        set_wr(1, 1, 1, 1, 1, 1, 1, 1, 15);
        run_xfer("stretch", 2, 16'h5A5A, 0);
    endtask

    task automatic test_read_in_oe();
        set_rd(0, 2, 4, 1, 3, 4);
        run_xfer("read", 3, 16'h0, 0);
    endtask

    task automatic test_read_gran();
        set_rd(1, 2, 3, 1, 0, 3);
        run_xfer("R2 read gran", 3, 16'h0, 0);
    endtask

    task automatic test_read_late_acc();
        set_rd(0, 1, 2, 1, 2, 15);
        run_xfer("read late", 3, 16'h0, 0);
    endtask

    task automatic test_busy_ignore();
        set_wr(0, 1, 1, 1, 2, 1, 1, 1, 0);
        run_xfer("R10 busy poke", 0, 16'h0042, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_cmd_write();
        test_addr_gran();
        test_zero_fields();
        test_cycle_stretch();
        test_read_in_oe();
        test_read_gran();
        test_read_late_acc();
        test_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule